// File: doc/BRIEF.md
# Multi-Lane Serial Word Aligner

This block sits behind the per-lane deserializers of a high-speed image sensor receiver. Each lane hands it eight serial bits per parallel clock, with the earliest bit in the most significant position. A gearbox in each lane regroups that bit stream into 10-bit pixel words, which it emits together with a valid strobe. Forty input bits become four words, so a word appears on four of every five clocks.

Lanes can arrive several bit periods apart, more than the analog delay taps can absorb. For that reason each lane also carries a search controller. While the training input is high, the controller compares every emitted word against the training word supplied on a port. On a mismatch it tells the gearbox to drop one bit, which moves the word boundary by one position. It then lets a few words pass before it compares again. Once a lane has seen enough consecutive matches it reports lock. A lane that has tried all ten boundary positions without success raises an error flag and keeps searching. A common aligned output tells downstream logic that every lane is locked.

When training is low the controllers stand still. Boundaries and lock flags keep their values while pixel data flows.

Top module: `lane_word_aligner`

## Requirements
- R1: Each gearbox outputs one 10-bit word per 10 input bits. With no slip requested, exactly 40 valid words appear per lane in any 50 consecutive clocks, and two clocks in a row are never both without a word once data is flowing.
- R2: Serial order is MSB first. Input bit 7 is the earliest bit of a byte, and output bit 9 is the earliest bit of a word. After alignment, every lane reproduces the transmitted pixel words in order, with none lost, duplicated or altered.
- R3: While training is high, a word that differs from the training word makes the lane drop one bit. Three further valid words are then ignored before the next comparison. Any starting bit offset from 0 to 9 therefore ends in lock.
- R4: A lane sets its lock flag only after 16 consecutive valid words equal the training word. Lock never rises before the lane has emitted 16 valid words since reset.
- R5: While training is high, a mismatching word clears the lane's lock flag within two clocks of reaching the output.
- R6: After 10 slips without reaching lock, the lane sets its error flag and restarts its search. The flag stays set until the lane locks. Lock and error are never high together.
- R7: The aligned output equals the AND of all lane lock flags on every clock.
- R8: While training is low, no slip is issued and lock flags keep their values. Training low right after reset never produces lock.
- R9: During reset, all valid, lock and error flags and the aligned output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rstN | input | 1 | Active-low synchronous reset |
| laneData | input | LANES*IN_W | Deserialized bits, lane n in bits [n*IN_W +: IN_W], bit IN_W-1 earliest |
| trainingEn | input | 1 | High while the sensor sends training words |
| trainWord | input | WORD_W | Expected training word |
| wordOut | output | LANES*WORD_W | Recovered words, lane n in bits [n*WORD_W +: WORD_W] |
| wordValid | output | LANES | Per-lane word strobe |
| laneLocked | output | LANES | Per-lane lock flag |
| laneError | output | LANES | Per-lane search-exhausted flag |
| allAligned | output | 1 | High when every lane is locked |

## Verification
A wrong fill count or shift amount in a gearbox shows up within a few clocks at the output. The words come out rotated, or the four-in-five valid cadence breaks, so the first pixel after training no longer matches. A lane whose slip counter or settle counter is off either fails to lock inside the training window or locks early, before sixteen words have passed. Both show up against the per-lane word count. A stuck controller state shows on the lock and error flags within one word of the mismatch that should have moved it.

// File: rtl/aligner_pkg.sv
package aligner_pkg;
  // Strobes from a lane's search controller to its gearbox.
  typedef struct packed {
    logic slip;  // drop the oldest buffered bit on the next clock
  } laneStrobe_t;
endpackage

// File: rtl/lane_gearbox.sv
module lane_gearbox #(
  parameter int IN_W   = 8,
  parameter int WORD_W = 10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [IN_W-1:0]           din,
  input  aligner_pkg::laneStrobe_t  strobe,
  output logic [WORD_W-1:0]         wordOut,
  output logic                      wordValid
);
  // Buffer holds at most WORD_W-1 leftover bits plus one new input group.
  localparam int BUF_W  = WORD_W - 1 + IN_W;
  localparam int FILL_W = $clog2(BUF_W + 1);

  logic [BUF_W-1:0]  bufQ;
  logic [FILL_W-1:0] fillQ;
  logic [BUF_W-1:0]  bufShift;
  logic [FILL_W-1:0] fillSum;
  logic              emit;

  always_comb begin
    // The oldest valid bit sits at position fillQ-1; new bits enter at the bottom.
    bufShift = (bufQ << IN_W) | BUF_W'(din);
    fillSum  = fillQ + FILL_W'(IN_W) - FILL_W'(strobe.slip);
    emit     = fillSum >= FILL_W'(WORD_W);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufQ      <= '0;
      fillQ     <= '0;
      wordOut   <= '0;
      wordValid <= 1'b0;
    end else begin
      bufQ      <= bufShift;
      wordValid <= emit;
      if (emit) begin
        wordOut <= WORD_W'(bufShift >> (fillSum - FILL_W'(WORD_W)));
        fillQ   <= fillSum - FILL_W'(WORD_W);
      end else begin
        fillQ   <= fillSum;
      end
    end
  end

  // R1: leftover bits never form a complete word.
  p_fill_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    fillQ < FILL_W'(WORD_W));

  // R1: once bits are buffered, a clock without a word is followed by a word.
  p_no_double_gap_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!wordValid && fillQ != '0) |=> wordValid);
endmodule

// File: rtl/lane_align_ctrl.sv
module lane_align_ctrl #(
  parameter int WORD_W     = 10,
  parameter int LOCK_COUNT = 16,
  parameter int SETTLE     = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      trainingEn,
  input  logic [WORD_W-1:0]         trainWord,
  input  logic [WORD_W-1:0]         wordIn,
  input  logic                      wordValid,
  output aligner_pkg::laneStrobe_t  strobe,
  output logic                      locked,
  output logic                      slipErr
);
  localparam int MATCH_W  = $clog2(LOCK_COUNT);
  localparam int SLIP_W   = $clog2(WORD_W);
  localparam int SETTLE_W = $clog2(SETTLE + 1);

  logic [MATCH_W-1:0]  matchQ;
  logic [SLIP_W-1:0]   slipCntQ;
  logic [SETTLE_W-1:0] settleQ;
  logic                slipQ;

  assign strobe.slip = slipQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchQ   <= '0;
      slipCntQ <= '0;
      settleQ  <= '0;
      slipQ    <= 1'b0;
      locked   <= 1'b0;
      slipErr  <= 1'b0;
    end else begin
      slipQ <= 1'b0;
      if (trainingEn && wordValid) begin
        if (settleQ != '0) begin
          settleQ <= settleQ - 1'b1;
        end else if (wordIn == trainWord) begin
          if (!locked) begin
            if (matchQ == MATCH_W'(LOCK_COUNT - 1)) begin
              locked   <= 1'b1;
              slipErr  <= 1'b0;
              slipCntQ <= '0;
              matchQ   <= '0;
            end else begin
              matchQ <= matchQ + 1'b1;
            end
          end
        end else begin
          locked  <= 1'b0;
          matchQ  <= '0;
          slipQ   <= 1'b1;
          settleQ <= SETTLE_W'(SETTLE);
          if (slipCntQ == SLIP_W'(WORD_W - 1)) begin
            slipCntQ <= '0;
            slipErr  <= 1'b1;
          end else begin
            slipCntQ <= slipCntQ + 1'b1;
          end
        end
      end
    end
  end

  // R8: a slip is only issued when training was high at the deciding edge.
  p_slip_needs_training_r8: assert property (@(posedge clk) disable iff (!rstN)
    slipQ |-> $past(trainingEn));

  // R8: with training low, the lock flag holds its value.
  p_lock_hold_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(trainingEn) |-> $stable(locked));

  // R6: lock and the exhausted-search flag exclude each other.
  p_lock_err_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> !slipErr);
endmodule

// File: rtl/lane_word_aligner.sv
module lane_word_aligner #(
  parameter int LANES      = 4,
  parameter int IN_W       = 8,
  parameter int WORD_W     = 10,
  parameter int LOCK_COUNT = 16,
  parameter int SETTLE     = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [LANES*IN_W-1:0]     laneData,
  input  logic                      trainingEn,
  input  logic [WORD_W-1:0]         trainWord,
  output logic [LANES*WORD_W-1:0]   wordOut,
  output logic [LANES-1:0]          wordValid,
  output logic [LANES-1:0]          laneLocked,
  output logic [LANES-1:0]          laneError,
  output logic                      allAligned
);
  aligner_pkg::laneStrobe_t strobes [LANES];

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    lane_gearbox #(.IN_W(IN_W), .WORD_W(WORD_W)) u_gear (
      .clk       (clk),
      .rstN      (rstN),
      .din       (laneData[n*IN_W +: IN_W]),
      .strobe    (strobes[n]),
      .wordOut   (wordOut[n*WORD_W +: WORD_W]),
      .wordValid (wordValid[n])
    );

    lane_align_ctrl #(.WORD_W(WORD_W), .LOCK_COUNT(LOCK_COUNT), .SETTLE(SETTLE)) u_ctrl (
      .clk        (clk),
      .rstN       (rstN),
      .trainingEn (trainingEn),
      .trainWord  (trainWord),
      .wordIn     (wordOut[n*WORD_W +: WORD_W]),
      .wordValid  (wordValid[n]),
      .strobe     (strobes[n]),
      .locked     (laneLocked[n]),
      .slipErr    (laneError[n])
    );
  end

  assign allAligned = &laneLocked;
endmodule

// File: tb/tb_lane_word_aligner.sv
module tb_lane_word_aligner;
  localparam int NL     = 10;
  localparam int IN_W   = 8;
  localparam int WORD_W = 10;
  localparam int SBITS  = 4000;
  localparam logic [WORD_W-1:0] TRAIN = 10'h3A6;
  localparam logic [WORD_W-1:0] ALT   = 10'h155;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NL*IN_W-1:0]   laneData = '0;
  logic                 trainingEn = 1'b0;
  logic [WORD_W-1:0]    trainWord = TRAIN;
  logic [NL*WORD_W-1:0] wordOut;
  logic [NL-1:0]        wordValid, laneLocked, laneError;
  logic                 allAligned;

  lane_word_aligner #(.LANES(NL), .IN_W(IN_W), .WORD_W(WORD_W)) dut (
    .clk(clk), .rstN(rstN), .laneData(laneData), .trainingEn(trainingEn),
    .trainWord(trainWord), .wordOut(wordOut), .wordValid(wordValid),
    .laneLocked(laneLocked), .laneError(laneError), .allAligned(allAligned)
  );

  always #10 clk = ~clk;  // 50 MHz

  logic [0:SBITS-1] streams [NL];
  int  ptr;
  int  checks = 0, fails = 0;
  bit  finished = 0;
  bit  pixMon = 0, holdMon = 0;
  bit  started [NL];
  int  pixIdx [NL];
  int  validCnt [NL];
  int  windowCnt [NL];
  bit  countWin = 0;
  logic [NL-1:0] prevLocked;

  function automatic logic [WORD_W-1:0] pix(int lane, int k);
    return WORD_W'((lane * 37 + k * 3 + 1) & 8'hFF);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Lane l: l zero bits (bit offset), then 200+(l%4) training words, then pixels.
  task automatic buildStreams();
    for (int l = 0; l < NL; l++) begin
      int p = 0;
      streams[l] = '0;
      p = l;
      for (int w = 0; w < 200 + (l % 4); w++)
        for (int b = WORD_W - 1; b >= 0; b--) begin streams[l][p] = TRAIN[b]; p++; end
      for (int k = 0; p + WORD_W <= SBITS; k++) begin
        logic [WORD_W-1:0] v = pix(l, k);
        for (int b = WORD_W - 1; b >= 0; b--) begin streams[l][p] = v[b]; p++; end
      end
    end
  endtask

  task automatic driveByte();
    for (int l = 0; l < NL; l++)
      for (int k = 0; k < IN_W; k++)
        laneData[l*IN_W + IN_W - 1 - k] = streams[l][ptr*IN_W + k];
    ptr++;
  endtask

  task automatic observe();
    check(allAligned == &laneLocked, "R7 aligned", allAligned, &laneLocked);
    for (int l = 0; l < NL; l++) begin
      logic [WORD_W-1:0] w = wordOut[l*WORD_W +: WORD_W];
      if (wordValid[l]) validCnt[l]++;
      if (countWin && wordValid[l]) windowCnt[l]++;
      if (laneLocked[l] && !prevLocked[l])
        check(validCnt[l] >= 16, "R4 early lock", validCnt[l], 16);
      if (holdMon) check(laneLocked[l], "R8 lock held", laneLocked[l], 1);
      if (pixMon && wordValid[l]) begin
        if (!started[l]) begin
          if (w != TRAIN) begin
            started[l] = 1;
            check(w == pix(l, 0), "R2 first pixel", w, pix(l, 0));
            pixIdx[l] = 1;
          end
        end else begin
          check(w == pix(l, pixIdx[l]), "R2 pixel", w, pix(l, pixIdx[l]));
          pixIdx[l]++;
        end
      end
    end
    prevLocked = laneLocked;
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      observe();
      driveByte();
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; laneData = '0;
    repeat (3) @(negedge clk);
    check(wordValid == '0 && laneLocked == '0 && laneError == '0 && !allAligned,
          "R9 reset state", {wordValid, laneLocked}, 0);
    ptr = 0;
    prevLocked = '0;
    for (int l = 0; l < NL; l++) begin
      validCnt[l] = 0; windowCnt[l] = 0; started[l] = 0; pixIdx[l] = 0;
    end
    rstN = 1'b1;
    driveByte();
  endtask

  initial begin
    buildStreams();
    // Phase 1: offsets 0..9 on the ten lanes, training then pixel data.
    trainingEn = 1'b1;
    doReset();
    step(200);
    check(laneLocked == '1, "R3 all offsets locked", laneLocked, '1);
    check(allAligned, "R7 aligned after lock", allAligned, 1);
    trainingEn = 1'b0;
    pixMon = 1; holdMon = 1;
    step(10);
    countWin = 1;
    step(50);
    countWin = 0;
    for (int l = 0; l < NL; l++)
      check(windowCnt[l] == 40, "R1 words per 50 clocks", windowCnt[l], 40);
    step(70);
    for (int l = 0; l < NL; l++)
      check(pixIdx[l] >= 30, "R2 pixel count", pixIdx[l], 30);
    pixMon = 0; holdMon = 0;

    // Phase 2: no lock without training, loss of lock, exhausted search.
    trainingEn = 1'b0;
    doReset();
    step(30);
    check(laneLocked == '0, "R8 no lock when idle", laneLocked, 0);
    trainingEn = 1'b1;
    step(200);
    check(laneLocked == '1, "R3 relock", laneLocked, '1);
    trainWord = ALT;
    step(4);
    check(laneLocked == '0, "R5 lock cleared", laneLocked, 0);
    check(!allAligned, "R7 aligned cleared", allAligned, 0);
    step(200);
    check(laneError == '1, "R6 search exhausted", laneError, '1);
    check(laneLocked == '0, "R6 no lock", laneLocked, 0);
    trainingEn = 1'b0;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule